// File: doc/BRIEF.md
# Direction-Selective Ganglion Combiner

This block computes one frame of a direction-selective output layer for a small image held inside the block. An excitatory frame and an inhibitory frame (the output of an upstream motion detector) are streamed in as pixel pairs. A start pulse then launches a pass. Each output pixel combines four terms. The first is a 7x7 centre-weighted sum over the excitatory frame. The second, subtracted from it, is a 7x7 sparse directional sum over the inhibitory frame. The third is the block's own output from the previous pass, multiplied by a decay factor. Finally the total is clamped and thresholded. The directional kernel holds nine equal taps on three arcs that point along one of six hexagonal axes. Motion along the selected axis is cancelled, and motion in other directions passes through.

The hexagonal neighbourhood is represented only by its mapping onto rectangular row and column offsets. Results stay in an internal result memory. They are read back through a registered read port, and the same memory supplies the previous output on the next pass. A one-cycle done pulse marks the end of a pass.

Top module: `ganglion_dirsel`

## Requirements
- R1: After reset, in_ready is 1, done is 0, and every result location reads as 0.
- R2: A pixel pair is taken on each clock edge where in_valid and in_ready are both 1. The k-th accepted pair since the last accepted start goes to raster index k, which is row*IMG_W+col, and the index wraps after IMG_W*IMG_H pairs. in_ready is 0 from the edge that accepts start until done, and pairs offered while it is 0 are dropped.
- R3: The excitatory weight at row/column offset (dr,dc) depends on m = max(|dr|,|dc|). It is 100 for m=0, 25 for m=1, 10 for m=2 and 4 for m=3, except that it is 0 where |dr|=|dc|=3.
- R4: Axis a has the unit vector u(a), given as (row,col): 0:(0,+1), 1:(-1,+1), 2:(-1,0), 3:(0,-1), 4:(+1,-1), 5:(+1,0). The inhibitory weight is 30 at the nine offsets k*u(a), (k-1)*u(a)+u(a+1) and (k-1)*u(a)+u(a-1), for k=1..3 with indices mod 6. It is 0 at all other offsets.
- R5: axis_sel is sampled on the edge that accepts start. The values 6 and 7 select axis 0.
- R6: Output pixel (r,c) weights input pixel (r+dr,c+dc). Input positions outside the image count as 0.
- R7: Let E and I be the excitatory and inhibitory sums, and P the previous output of the pixel. Then t = floor((E-I)/256) + floor(P*DECAY/256). Negative t becomes 0. The result is 0 if t < THRESH, and otherwise min(t, 2^PIX_W-1).
- R8: P is the value that the previous pass wrote to the same pixel, or 0 if there was no previous pass since reset.
- R9: done is high for exactly one cycle. That cycle starts 50*IMG_W*IMG_H clock edges after the edge that accepted start, and in_ready returns to 1 on the next edge.
- R10: A start pulse while in_ready is 0 is ignored. The running pass and its results are unchanged, and no second pass follows.
- R11: rd_data shows the result at rd_addr one clock edge after the address is presented. It holds its value while the address stays put and no pass writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Pixel pair offered |
| in_ready | output | 1 | Block accepts pixel pairs (idle) |
| in_exc | input | PIX_W | Excitatory pixel |
| in_inh | input | PIX_W | Inhibitory pixel |
| start | input | 1 | Launch one pass |
| axis_sel | input | 3 | Inhibited hexagonal axis, 0..5 |
| done | output | 1 | One-cycle end-of-pass pulse |
| rd_addr | input | clog2(IMG_W*IMG_H) | Result read address |
| rd_data | output | PIX_W | Registered result data |

## Verification
Each pass takes 49 accumulate cycles and one write cycle per pixel. done is therefore due exactly 50*IMG_W*IMG_H edges after the start edge. The bench counts edges from that start edge and samples done one nanosecond after each edge, so the check lands on the exact cycle. Read-back data is due one edge after the address is driven on a falling edge, and is sampled just after that rising edge. A reference model built from the weight and arithmetic rules pushes each pass's expected frame into a queue, and the read-back monitor pops and compares it, so decay across successive passes is carried through the model.

// File: rtl/gc_pkg.sv
`timescale 1ns/1ps
package gc_pkg;
  localparam int KDIM    = 7;
  localparam int KRAD    = 3;
  localparam int NAXES   = 6;
  localparam int INH_TAP = 30;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_WRITE, ST_FIN} gc_state_e;

  function automatic int axis_dr(input int a);
    case (a)
      1, 2:    return -1;
      4, 5:    return 1;
      default: return 0;
    endcase
  endfunction

  function automatic int axis_dc(input int a);
    case (a)
      0, 1:    return 1;
      3, 4:    return -1;
      default: return 0;
    endcase
  endfunction

  // centre-weighted ring coupling, corners cut
  function automatic logic [6:0] exc_weight(input logic signed [3:0] dr,
                                            input logic signed [3:0] dc);
    int r, c, m;
    r = (int'(dr) < 0) ? -int'(dr) : int'(dr);
    c = (int'(dc) < 0) ? -int'(dc) : int'(dc);
    m = (r > c) ? r : c;
    if (r == KRAD && c == KRAD) return 7'd0;
    case (m)
      0:       return 7'd100;
      1:       return 7'd25;
      2:       return 7'd10;
      default: return 7'd4;
    endcase
  endfunction

  // nine taps on three arcs pointing along axis a
  function automatic logic [4:0] inh_weight(input int a,
                                            input logic signed [3:0] dr,
                                            input logic signed [3:0] dc);
    int r, c, ar, ac, nr, nc, pr, pc;
    logic hit;
    r  = int'(dr);
    c  = int'(dc);
    ar = axis_dr(a);
    ac = axis_dc(a);
    nr = axis_dr((a + 1) % NAXES);
    nc = axis_dc((a + 1) % NAXES);
    pr = axis_dr((a + NAXES - 1) % NAXES);
    pc = axis_dc((a + NAXES - 1) % NAXES);
    hit = 1'b0;
    for (int k = 1; k <= KRAD; k++) begin
      if (r == k * ar && c == k * ac) hit = 1'b1;
      if (r == (k - 1) * ar + nr && c == (k - 1) * ac + nc) hit = 1'b1;
      if (r == (k - 1) * ar + pr && c == (k - 1) * ac + pc) hit = 1'b1;
    end
    return hit ? 5'(INH_TAP) : 5'd0;
  endfunction
endpackage

// File: rtl/gc_weights.sv
`timescale 1ns/1ps
module gc_weights
  import gc_pkg::*;
(
  input  logic [2:0] axis,
  input  logic [2:0] tap_r,
  input  logic [2:0] tap_c,
  output logic [6:0] w_exc,
  output logic [4:0] w_inh
);
  logic signed [3:0] dr, dc;
  logic [4:0] inh_axis [NAXES];

  assign dr = $signed({1'b0, tap_r}) - 4'sd3;
  assign dc = $signed({1'b0, tap_c}) - 4'sd3;

  for (genvar a = 0; a < NAXES; a++) begin : g_axis
    assign inh_axis[a] = inh_weight(a, dr, dc);
  end

  assign w_exc = exc_weight(dr, dc);
  assign w_inh = (axis < 3'(NAXES)) ? inh_axis[axis] : inh_axis[0];
endmodule

// File: rtl/gc_mac.sv
`timescale 1ns/1ps
module gc_mac #(
  parameter int PIX_W = 8,
  parameter int EW    = PIX_W + 10,
  parameter int IW    = PIX_W + 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             en,
  input  logic [PIX_W-1:0] px_exc,
  input  logic [PIX_W-1:0] px_inh,
  input  logic [6:0]       w_exc,
  input  logic [4:0]       w_inh,
  output logic [EW-1:0]    acc_exc,
  output logic [IW-1:0]    acc_inh
);
  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      acc_exc <= '0;
      acc_inh <= '0;
    end else if (en) begin
      acc_exc <= acc_exc + EW'(w_exc) * EW'(px_exc);
      acc_inh <= acc_inh + IW'(w_inh) * IW'(px_inh);
    end
  end
endmodule

// File: rtl/gc_combine.sv
`timescale 1ns/1ps
module gc_combine #(
  parameter int PIX_W  = 8,
  parameter int EW     = PIX_W + 10,
  parameter int IW     = PIX_W + 9,
  parameter int DECAY  = 128,
  parameter int THRESH = 8
) (
  input  logic [EW-1:0]    acc_exc,
  input  logic [IW-1:0]    acc_inh,
  input  logic [PIX_W-1:0] prev,
  output logic [PIX_W-1:0] result
);
  localparam int SHIFT = 8;
  localparam int DW    = 9;
  localparam int PW    = PIX_W + DW;
  localparam int SW    = EW + 3;
  localparam int MAXV  = (1 << PIX_W) - 1;

  logic signed [SW-1:0] e_s, i_s, d_s, k_s, t_s;
  logic [PW-1:0] prod;

  assign e_s  = $signed(SW'(acc_exc));
  assign i_s  = $signed(SW'(acc_inh));
  assign d_s  = (e_s - i_s) >>> SHIFT;
  assign prod = PW'(prev) * PW'(DECAY);
  assign k_s  = $signed(SW'(prod >> SHIFT));
  assign t_s  = d_s + k_s;

  always_comb begin
    if (t_s < 0 || t_s < THRESH) result = '0;
    else if (t_s > MAXV)         result = '1;
    else                         result = t_s[PIX_W-1:0];
  end
endmodule

// File: rtl/gc_scan.sv
`timescale 1ns/1ps
module gc_scan
  import gc_pkg::*;
#(
  parameter int IMG_W = 8,
  parameter int IMG_H = 8,
  parameter int RW    = $clog2(IMG_H),
  parameter int CW    = $clog2(IMG_W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  output logic          busy,
  output logic          done,
  output logic          acc_en,
  output logic          acc_clear,
  output logic          wr_en,
  output logic [RW-1:0] pix_r,
  output logic [CW-1:0] pix_c,
  output logic [2:0]    tap_r,
  output logic [2:0]    tap_c
);
  localparam logic [2:0] TAP_LAST = 3'(KDIM - 1);
  gc_state_e state;
  logic last_pix;

  assign last_pix  = (pix_r == RW'(IMG_H - 1)) && (pix_c == CW'(IMG_W - 1));
  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_FIN);
  assign acc_en    = (state == ST_RUN);
  assign wr_en     = (state == ST_WRITE);
  assign acc_clear = (state == ST_WRITE) || (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      pix_r <= '0;
      pix_c <= '0;
      tap_r <= '0;
      tap_c <= '0;
    end else begin
      case (state)
        ST_IDLE: if (go) begin
          state <= ST_RUN;
          pix_r <= '0;
          pix_c <= '0;
          tap_r <= '0;
          tap_c <= '0;
        end
        ST_RUN: begin
          if (tap_c == TAP_LAST) begin
            tap_c <= '0;
            if (tap_r == TAP_LAST) begin
              tap_r <= '0;
              state <= ST_WRITE;
            end else begin
              tap_r <= tap_r + 3'd1;
            end
          end else begin
            tap_c <= tap_c + 3'd1;
          end
        end
        ST_WRITE: begin
          if (last_pix) begin
            state <= ST_FIN;
          end else begin
            state <= ST_RUN;
            if (pix_c == CW'(IMG_W - 1)) begin
              pix_c <= '0;
              pix_r <= pix_r + RW'(1);
            end else begin
              pix_c <= pix_c + CW'(1);
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ganglion_dirsel.sv
`timescale 1ns/1ps
module ganglion_dirsel
  import gc_pkg::*;
#(
  parameter int IMG_W  = 8,
  parameter int IMG_H  = 8,
  parameter int PIX_W  = 8,
  parameter int DECAY  = 128,
  parameter int THRESH = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              in_valid,
  output logic                              in_ready,
  input  logic [PIX_W-1:0]                  in_exc,
  input  logic [PIX_W-1:0]                  in_inh,
  input  logic                              start,
  input  logic [2:0]                        axis_sel,
  output logic                              done,
  input  logic [$clog2(IMG_W*IMG_H)-1:0]    rd_addr,
  output logic [PIX_W-1:0]                  rd_data
);
  localparam int NPIX = IMG_W * IMG_H;
  localparam int AW   = $clog2(NPIX);
  localparam int RW   = $clog2(IMG_H);
  localparam int CW   = $clog2(IMG_W);
  localparam int SCW  = ((RW > CW) ? RW : CW) + 2;
  localparam int EW   = PIX_W + 10;
  localparam int IW   = PIX_W + 9;

  logic [PIX_W-1:0] exc_mem [NPIX];
  logic [PIX_W-1:0] inh_mem [NPIX];
  logic [PIX_W-1:0] out_mem [NPIX];

  logic busy, go, load, acc_en, acc_clear, wr_en;
  logic [AW-1:0] ld_ptr, saddr, pix_addr;
  logic [RW-1:0] pix_r;
  logic [CW-1:0] pix_c;
  logic [2:0] tap_r, tap_c, dir_q;
  logic signed [3:0] dr, dc;
  logic signed [SCW-1:0] sr, sc;
  logic inb;
  logic [PIX_W-1:0] px_exc, px_inh, result;
  logic [6:0] w_exc;
  logic [4:0] w_inh;
  logic [EW-1:0] acc_exc;
  logic [IW-1:0] acc_inh;

  assign in_ready = !busy;
  assign go       = start && !busy;
  assign load     = in_valid && in_ready;

  // input loading, raster order
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ld_ptr <= '0;
    end else if (go) begin
      ld_ptr <= '0;
    end else if (load) begin
      ld_ptr <= (ld_ptr == AW'(NPIX - 1)) ? '0 : ld_ptr + AW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      exc_mem[ld_ptr] <= in_exc;
      inh_mem[ld_ptr] <= in_inh;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) dir_q <= '0;
    else if (go) dir_q <= (axis_sel < 3'(NAXES)) ? axis_sel : 3'd0;
  end

  gc_scan #(.IMG_W(IMG_W), .IMG_H(IMG_H), .RW(RW), .CW(CW)) u_scan (
    .clk(clk), .rst_n(rst_n), .go(go), .busy(busy), .done(done),
    .acc_en(acc_en), .acc_clear(acc_clear), .wr_en(wr_en),
    .pix_r(pix_r), .pix_c(pix_c), .tap_r(tap_r), .tap_c(tap_c)
  );

  // source coordinate of the current tap, zero outside the frame
  assign dr  = $signed({1'b0, tap_r}) - 4'sd3;
  assign dc  = $signed({1'b0, tap_c}) - 4'sd3;
  assign sr  = $signed(SCW'(pix_r)) + SCW'(dr);
  assign sc  = $signed(SCW'(pix_c)) + SCW'(dc);
  assign inb = (sr >= 0) && (sr < IMG_H) && (sc >= 0) && (sc < IMG_W);
  assign saddr    = AW'(sr[RW-1:0]) * AW'(IMG_W) + AW'(sc[CW-1:0]);
  assign pix_addr = AW'(pix_r) * AW'(IMG_W) + AW'(pix_c);
  assign px_exc   = inb ? exc_mem[saddr] : '0;
  assign px_inh   = inb ? inh_mem[saddr] : '0;

  gc_weights u_weights (
    .axis(dir_q), .tap_r(tap_r), .tap_c(tap_c), .w_exc(w_exc), .w_inh(w_inh)
  );

  gc_mac #(.PIX_W(PIX_W), .EW(EW), .IW(IW)) u_mac (
    .clk(clk), .rst_n(rst_n), .clear(acc_clear), .en(acc_en),
    .px_exc(px_exc), .px_inh(px_inh), .w_exc(w_exc), .w_inh(w_inh),
    .acc_exc(acc_exc), .acc_inh(acc_inh)
  );

  gc_combine #(.PIX_W(PIX_W), .EW(EW), .IW(IW), .DECAY(DECAY), .THRESH(THRESH)) u_comb (
    .acc_exc(acc_exc), .acc_inh(acc_inh), .prev(out_mem[pix_addr]), .result(result)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NPIX; i++) out_mem[i] <= '0;
    end else if (wr_en) begin
      out_mem[pix_addr] <= result;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= out_mem[rd_addr];
  end
endmodule

// File: rtl/gc_checker.sv
`timescale 1ns/1ps
module gc_checker #(
  parameter int AW    = 6,
  parameter int PIX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             in_ready,
  input logic             done,
  input logic             wr_en,
  input logic [2:0]       dir_q,
  input logic [AW-1:0]    rd_addr,
  input logic [PIX_W-1:0] rd_data
);
  p_start_locks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start && in_ready |=> !in_ready);

  p_write_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !in_ready);

  p_axis_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dir_q < 3'd6);

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !in_ready);

  p_done_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> in_ready);

  p_read_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(rd_addr) && !$past(wr_en) |=> $stable(rd_data));
endmodule

bind ganglion_dirsel gc_checker #(.AW($clog2(IMG_W*IMG_H)), .PIX_W(PIX_W)) u_checker (
  .clk(clk), .rst_n(rst_n), .start(start), .in_ready(in_ready), .done(done),
  .wr_en(wr_en), .dir_q(dir_q), .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/test_ganglion_dirsel.sv
`timescale 1ns/1ps
module test_ganglion_dirsel;
  localparam int W = 8, H = 8, N = W * H, PW = 8, DEC = 128, THR = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, start = 1'b0;
  logic [PW-1:0] in_exc = '0, in_inh = '0;
  logic [2:0] axis_sel = '0;
  logic [5:0] rd_addr = '0;
  logic in_ready, done;
  logic [PW-1:0] rd_data;

  int tests = 0, fails = 0;
  int m_exc[N], m_inh[N], m_prev[N];
  int exp_q[$];

  always #4 clk = ~clk;

  ganglion_dirsel #(.IMG_W(W), .IMG_H(H), .PIX_W(PW), .DECAY(DEC), .THRESH(THR)) i_ganglion_dirsel (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_exc(in_exc), .in_inh(in_inh), .start(start), .axis_sel(axis_sel),
    .done(done), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic check(input string tag, input int act, input int expv);
    tests++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // R3 ring weights
  function automatic int w_ring(input int dr, input int dc);
    int r, c, m;
    r = dr < 0 ? -dr : dr;
    c = dc < 0 ? -dc : dc;
    m = r > c ? r : c;
    if (r == 3 && c == 3) return 0;
    case (m) 0: return 100; 1: return 25; 2: return 10; default: return 4; endcase
  endfunction

  // R4 arc weights
  function automatic int w_arc(input int a, input int dr, input int dc);
    int ur[6] = '{0, -1, -1, 0, 1, 1};
    int uc[6] = '{1, 1, 0, -1, -1, 0};
    int n, p;
    n = (a + 1) % 6;
    p = (a + 5) % 6;
    for (int k = 1; k <= 3; k++) begin
      if (dr == k * ur[a] && dc == k * uc[a]) return 30;
      if (dr == (k - 1) * ur[a] + ur[n] && dc == (k - 1) * uc[a] + uc[n]) return 30;
      if (dr == (k - 1) * ur[a] + ur[p] && dc == (k - 1) * uc[a] + uc[p]) return 30;
    end
    return 0;
  endfunction

  // driver side of the scoreboard: R6 R7 R8 model
  task automatic predict(input int axis);
    int a, e, i, d, t, r, c;
    a = (axis > 5) ? 0 : axis;
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++) begin
        e = 0; i = 0;
        for (int dr = -3; dr <= 3; dr++)
          for (int dc = -3; dc <= 3; dc++) begin
            r = y + dr; c = x + dc;
            if (r >= 0 && r < H && c >= 0 && c < W) begin
              e += w_ring(dr, dc) * m_exc[r * W + c];
              i += w_arc(a, dr, dc) * m_inh[r * W + c];
            end
          end
        d = (e - i) >>> 8;
        t = d + ((m_prev[y * W + x] * DEC) >>> 8);
        if (t < 0) t = 0;
        t = (t < THR) ? 0 : (t > 255 ? 255 : t);
        m_prev[y * W + x] = t;
        exp_q.push_back(t);
      end
  endtask

  task automatic drive_frame();
    for (int k = 0; k < N; k++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_exc = PW'(m_exc[k]);
      in_inh = PW'(m_inh[k]);
      if (k == 0) check("R2 ready while idle", int'(in_ready), 1);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor side: pop expected and compare with read-back
  task automatic monitor(input string tag);
    int expv;
    for (int k = 0; k < N; k++) begin
      @(negedge clk);
      rd_addr = 6'(k);
      @(posedge clk);
      #1;
      expv = exp_q.pop_front();
      check(tag, int'(rd_data), expv);
    end
  endtask

  task automatic run_pass(input int axis, input string tag, input bit inject);
    int cyc;
    predict(axis);
    @(negedge clk);
    start = 1'b1;
    axis_sel = 3'(axis);
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    fork
      begin
        while (cyc < 60 * N) begin
          @(posedge clk);
          cyc++;
          #1;
          if (cyc == 1) check("R2 busy after start", int'(in_ready), 0);
          if (done) break;
        end
        check("R9 done cycle", cyc, 50 * N);
        @(posedge clk);
        #1;
        check("R9 done one cycle", int'(done), 0);
        check("R9 ready again", int'(in_ready), 1);
      end
      begin
        if (inject) begin
          repeat (20) @(negedge clk);
          start = 1'b1; axis_sel = 3'd3;
          in_valid = 1'b1; in_exc = '1; in_inh = '1;
          repeat (5) @(negedge clk);
          start = 1'b0; in_valid = 1'b0;
        end
      end
    join
    monitor(tag);
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    tests++;
    $display("FAIL R9 watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < N; k++) m_prev[k] = 0;
    repeat (4) @(posedge clk);
    #1;
    check("R1 ready in reset", int'(in_ready), 1);
    check("R1 done in reset", int'(done), 0);
    @(negedge clk);
    rst_n = 1'b1;
    rd_addr = 6'd9;
    @(posedge clk);
    #1;
    check("R1 result cleared", int'(rd_data), 0);
    check("R1 ready after reset", int'(in_ready), 1);

    // T1: varied excitatory, no inhibition, borders padded
    for (int k = 0; k < N; k++) begin m_exc[k] = (k * 13 + 7) % 64; m_inh[k] = 0; end
    drive_frame();
    run_pass(0, "R3 R6 R11 excitatory kernel", 1'b0);

    // T2: flat excitatory, inhibitory spot, axis 1, decay of T1
    for (int k = 0; k < N; k++) begin m_exc[k] = 100; m_inh[k] = 0; end
    m_inh[3 * W + 3] = 255;
    drive_frame();
    run_pass(1, "R4 R8 axis 1 arcs", 1'b0);

    // T3: asymmetric inhibitory spot, every axis
    for (int k = 0; k < N; k++) begin m_exc[k] = 60; m_inh[k] = 0; end
    m_inh[4 * W + 2] = 200;
    m_inh[1 * W + 6] = 150;
    for (int a = 2; a < 6; a++) begin
      drive_frame();
      run_pass(a, "R4 axis sweep", 1'b0);
    end

    // T4: out-of-range axis codes behave as axis 0
    drive_frame();
    run_pass(7, "R5 axis 7 as 0", 1'b0);
    drive_frame();
    run_pass(6, "R5 axis 6 as 0", 1'b0);

    // T5: zero input, only decayed previous output survives
    for (int k = 0; k < N; k++) begin m_exc[k] = 0; m_inh[k] = 0; end
    drive_frame();
    run_pass(0, "R8 R7 decay and threshold", 1'b0);

    // T6: heavy inhibition, negative totals clamp to zero
    for (int k = 0; k < N; k++) begin m_exc[k] = 0; m_inh[k] = 255; end
    drive_frame();
    run_pass(3, "R7 negative clamp", 1'b0);

    // T7: start and data offered while busy are dropped
    for (int k = 0; k < N; k++) begin m_exc[k] = (k * 29 + 3) % 96; m_inh[k] = (k * 7) % 50; end
    drive_frame();
    run_pass(4, "R10 R2 busy inputs ignored", 1'b1);
    repeat (3) @(posedge clk);
    #1;
    check("R10 no second pass", int'(in_ready), 1);
    check("R10 no done", int'(done), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule